// File: doc/BRIEF.md
# Dataflow Instruction Scheduler

This block decides which instruction an execution pipeline runs next, using completion signals instead of data tokens. Each of its slots holds an instruction's scheduling state: how many predecessor completions it still needs, a ready flag, a list of up to four successor slots, and a sequential-thread flag. The pipeline reports finished instructions on a done channel. For each report the scheduler walks the finished instruction's successor list and gives one signal to each successor. When a successor has received all the signals it needs, it becomes ready and its counter is re-armed so it can run again on a later loop trip. Ready instructions go back to the pipeline on a fire channel, which carries only a slot address. Operands never pass through here; the pipeline fetches them itself.

Some instructions belong to a sequential thread. When such an instruction finishes, the next slot in address order is fired at once, without any counting, so the thread runs in program order. Threads still synchronize with each other through the counters. A plain write strobe loads the program into the slots.

Both channels use valid/ready. The fire channel holds its address stable while stalled. The done channel drops its ready while a report is still being walked or while a shortcut fire is waiting.

Top module: `dfs_sched`

## Requirements
- R1: After reset, fire_valid is 0 and done_ready is 1, and no slot is ready.
- R2: A load strobe writes one slot: required count (0 to 3), successor number (0 to 4), successor list (entry k in bits [k*5+4:k*5]), thread flag and initial ready flag. The slot starts ready if the ready flag is 1 or the count is 0. Otherwise it waits.
- R3: When nothing is already being presented, fire presents the lowest-addressed ready slot. A handshake (fire_valid and fire_ready both high at a clock edge) clears that slot's ready flag.
- R4: A slot with required count C (2 or 3) becomes ready only on the C-th signal it receives, and not before.
- R5: When a slot becomes ready its counter is re-armed to the loaded count, so another C signals make it ready again.
- R6: A done report for an instruction with K successors, K from 1 to 4, delivers one signal per cycle to the listed successors. done_ready is low for the K cycles after acceptance. With K = 0, done_ready stays high.
- R7: A done report for a slot with the thread flag set makes fire present slot address+1 (slot 31 wraps to 0). This takes place whatever that slot's counter holds, leaves its counter unchanged, and wins over ready slots that are not already being presented.
- R8: While a shortcut fire waits to be taken, done_ready is 0.
- R9: When a fire handshake and the final signal to the same slot fall on one clock edge, the slot is fired and is also left ready again.
- R10: Once fire_valid is high with fire_ready low, fire_valid stays high and fire_addr stays the same until a handshake happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Write strobe for one slot |
| load_addr | input | 5 | Slot being written |
| load_cnt | input | 2 | Required signal count |
| load_nsucc | input | 3 | Number of successors, 0 to 4 |
| load_succ | input | 20 | Successor addresses, entry k at bits k*5 |
| load_vn | input | 1 | Sequential-thread flag |
| load_en | input | 1 | Initial ready flag |
| done_valid | input | 1 | Pipeline reports a finished instruction |
| done_ready | output | 1 | Scheduler accepts a done report |
| done_addr | input | 5 | Finished instruction's slot |
| fire_valid | output | 1 | An instruction is offered to the pipeline |
| fire_ready | input | 1 | Pipeline takes the offered instruction |
| fire_addr | output | 5 | Slot of the offered instruction |

## Verification
The hardest case to produce is R9. It needs a slot's last signal to land on the same edge as that slot's fire handshake. The bench keeps fire_ready low so the slot stays presented, and has a done report walk a one-entry successor list pointing at it. It then raises fire_ready only for the cycle in which that single delivery happens, which is one cycle after acceptance. The lowest-index priority and the shortcut priority are checked in a similar way. While the fire channel is held on one instruction, several more slots become ready or a shortcut becomes pending. The bench then watches which one is offered after the held instruction is taken.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic {WALK_IDLE = 1'b0, WALK_RUN = 1'b1} walk_state_e;
endpackage

// File: rtl/dfs_slot_table.sv
module dfs_slot_table #(
  parameter int N  = 32,
  parameter int S  = 4,
  parameter int CW = 2,
  parameter int AW = 5,
  parameter int NW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [AW-1:0]     load_addr,
  input  logic [CW-1:0]     load_cnt,
  input  logic [NW-1:0]     load_nsucc,
  input  logic [S*AW-1:0]   load_succ,
  input  logic              load_vn,
  input  logic              load_en,
  input  logic              del_valid,
  input  logic [AW-1:0]     del_addr,
  input  logic              clr_valid,
  input  logic [AW-1:0]     clr_addr,
  input  logic [AW-1:0]     rd_addr,
  output logic [NW-1:0]     rd_nsucc,
  output logic [S*AW-1:0]   rd_succ,
  output logic              rd_vn,
  output logic [N-1:0]      en_vec
);
  logic [CW-1:0]   init_q  [N];
  logic [CW-1:0]   rem_q   [N];
  logic            en_q    [N];
  logic            vn_q    [N];
  logic [NW-1:0]   nsucc_q [N];
  logic [S*AW-1:0] succ_q  [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic hit_load, hit_del, hit_clr, last_sig;
    assign hit_load = load_valid && (load_addr == AW'(g));
    assign hit_del  = del_valid && (del_addr == AW'(g));
    assign hit_clr  = clr_valid && (clr_addr == AW'(g));
    assign last_sig = rem_q[g] <= CW'(1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        init_q[g]  <= '0;
        rem_q[g]   <= '0;
        en_q[g]    <= 1'b0;
        vn_q[g]    <= 1'b0;
        nsucc_q[g] <= '0;
        succ_q[g]  <= '0;
      end else if (hit_load) begin
        init_q[g]  <= load_cnt;
        rem_q[g]   <= load_cnt;
        en_q[g]    <= load_en || (load_cnt == '0);
        vn_q[g]    <= load_vn;
        nsucc_q[g] <= load_nsucc;
        succ_q[g]  <= load_succ;
      end else begin
        if (hit_del) rem_q[g] <= last_sig ? init_q[g] : rem_q[g] - CW'(1);
        // a completing signal wins over a same-edge fire clear
        if (hit_del && last_sig) en_q[g] <= 1'b1;
        else if (hit_clr)        en_q[g] <= 1'b0;
      end
    end
    assign en_vec[g] = en_q[g];
  end

  assign rd_nsucc = nsucc_q[rd_addr];
  assign rd_succ  = succ_q[rd_addr];
  assign rd_vn    = vn_q[rd_addr];

  AST_EN_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (del_valid && rem_q[del_addr] <= CW'(1) && !(load_valid && load_addr == del_addr))
    |=> en_q[$past(del_addr)]); // R4
  AST_CLR_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> en_q[clr_addr]); // R3
endmodule

// File: rtl/dfs_done_walk.sv
module dfs_done_walk
  import dfs_pkg::*;
#(
  parameter int N  = 32,
  parameter int S  = 4,
  parameter int AW = 5,
  parameter int NW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done_valid,
  input  logic [AW-1:0]   done_addr,
  output logic            done_ready,
  output logic [AW-1:0]   rd_addr,
  input  logic [NW-1:0]   rd_nsucc,
  input  logic [S*AW-1:0] rd_succ,
  input  logic            rd_vn,
  output logic            del_valid,
  output logic [AW-1:0]   del_addr,
  input  logic            sc_take,
  output logic            sc_pend,
  output logic [AW-1:0]   sc_addr
);
  walk_state_e     state_q;
  logic [S*AW-1:0] succ_q;
  logic [NW-1:0]   num_q, idx_q;
  logic            accept;
  logic [AW-1:0]   next_addr;

  assign rd_addr    = done_addr;
  assign done_ready = (state_q == WALK_IDLE) && !sc_pend;
  assign accept     = done_valid && done_ready;
  assign next_addr  = (done_addr == AW'(N-1)) ? '0 : done_addr + AW'(1);
  assign del_valid  = (state_q == WALK_RUN);
  assign del_addr   = succ_q[idx_q*AW +: AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      succ_q  <= '0;
      num_q   <= '0;
      idx_q   <= '0;
      sc_pend <= 1'b0;
      sc_addr <= '0;
    end else begin
      if (accept) begin
        succ_q  <= rd_succ;
        num_q   <= rd_nsucc;
        idx_q   <= '0;
        state_q <= (rd_nsucc != '0) ? WALK_RUN : WALK_IDLE;
        if (rd_vn) begin
          sc_pend <= 1'b1;
          sc_addr <= next_addr;
        end
      end else if (state_q == WALK_RUN) begin
        idx_q <= idx_q + NW'(1);
        if (idx_q == num_q - NW'(1)) state_q <= WALK_IDLE;
      end
      if (sc_take) sc_pend <= 1'b0;
    end
  end

  AST_WALK_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WALK_RUN) |-> (idx_q < num_q)); // R6
endmodule

// File: rtl/dfs_fire_sel.sv
module dfs_fire_sel #(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  en_vec,
  input  logic          sc_pend,
  input  logic [AW-1:0] sc_addr,
  input  logic          fire_ready,
  output logic          fire_valid,
  output logic [AW-1:0] fire_addr,
  output logic          clr_valid,
  output logic [AW-1:0] clr_addr,
  output logic          sc_take
);
  logic          any_en, cur_sc, take;
  logic [AW-1:0] enc;
  logic          lock_q, lock_sc_q;
  logic [AW-1:0] lock_addr_q;

  always_comb begin
    any_en = 1'b0;
    enc    = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (en_vec[i]) begin
        any_en = 1'b1;
        enc    = AW'(i);
      end
    end
  end

  assign cur_sc     = lock_q ? lock_sc_q : sc_pend;
  assign fire_addr  = lock_q ? lock_addr_q : (sc_pend ? sc_addr : enc);
  assign fire_valid = lock_q || sc_pend || any_en;
  assign take       = fire_valid && fire_ready;
  assign sc_take    = take && cur_sc;
  assign clr_valid  = take && !cur_sc;
  assign clr_addr   = fire_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q      <= 1'b0;
      lock_sc_q   <= 1'b0;
      lock_addr_q <= '0;
    end else begin
      lock_q      <= fire_valid && !fire_ready;
      lock_sc_q   <= cur_sc;
      lock_addr_q <= fire_addr;
    end
  end
endmodule

// File: rtl/dfs_sched.sv
module dfs_sched #(
  parameter int N_SLOTS  = 32,
  parameter int MAX_SUCC = 4,
  parameter int CNT_W    = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  load_valid,
  input  logic [$clog2(N_SLOTS)-1:0]            load_addr,
  input  logic [CNT_W-1:0]                      load_cnt,
  input  logic [$clog2(MAX_SUCC+1)-1:0]         load_nsucc,
  input  logic [MAX_SUCC*$clog2(N_SLOTS)-1:0]   load_succ,
  input  logic                                  load_vn,
  input  logic                                  load_en,
  input  logic                                  done_valid,
  output logic                                  done_ready,
  input  logic [$clog2(N_SLOTS)-1:0]            done_addr,
  output logic                                  fire_valid,
  input  logic                                  fire_ready,
  output logic [$clog2(N_SLOTS)-1:0]            fire_addr
);
  localparam int AW = $clog2(N_SLOTS);
  localparam int NW = $clog2(MAX_SUCC+1);

  logic [AW-1:0]          rd_addr, del_addr, clr_addr, sc_addr;
  logic [NW-1:0]          rd_nsucc;
  logic [MAX_SUCC*AW-1:0] rd_succ;
  logic                   rd_vn, del_valid, clr_valid, sc_take, sc_pend;
  logic [N_SLOTS-1:0]     en_vec;

  dfs_slot_table #(.N(N_SLOTS), .S(MAX_SUCC), .CW(CNT_W), .AW(AW), .NW(NW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .load_valid(load_valid), .load_addr(load_addr), .load_cnt(load_cnt),
    .load_nsucc(load_nsucc), .load_succ(load_succ), .load_vn(load_vn), .load_en(load_en),
    .del_valid(del_valid), .del_addr(del_addr),
    .clr_valid(clr_valid), .clr_addr(clr_addr),
    .rd_addr(rd_addr), .rd_nsucc(rd_nsucc), .rd_succ(rd_succ), .rd_vn(rd_vn),
    .en_vec(en_vec)
  );

  dfs_done_walk #(.N(N_SLOTS), .S(MAX_SUCC), .AW(AW), .NW(NW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .done_valid(done_valid), .done_addr(done_addr), .done_ready(done_ready),
    .rd_addr(rd_addr), .rd_nsucc(rd_nsucc), .rd_succ(rd_succ), .rd_vn(rd_vn),
    .del_valid(del_valid), .del_addr(del_addr),
    .sc_take(sc_take), .sc_pend(sc_pend), .sc_addr(sc_addr)
  );

  dfs_fire_sel #(.N(N_SLOTS), .AW(AW)) u_fire (
    .clk(clk), .rst_n(rst_n),
    .en_vec(en_vec), .sc_pend(sc_pend), .sc_addr(sc_addr),
    .fire_ready(fire_ready), .fire_valid(fire_valid), .fire_addr(fire_addr),
    .clr_valid(clr_valid), .clr_addr(clr_addr), .sc_take(sc_take)
  );

  AST_FIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_valid && !fire_ready) |=> (fire_valid && $stable(fire_addr))); // R10
  AST_SC_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pend |-> fire_valid); // R7
endmodule

// File: tb/dfs_sched_bench.sv
`timescale 1ns/1ps
module dfs_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic [4:0]  load_addr = '0;
  logic [1:0]  load_cnt = '0;
  logic [2:0]  load_nsucc = '0;
  logic [19:0] load_succ = '0;
  logic        load_vn = 1'b0;
  logic        load_en = 1'b0;
  logic        done_valid = 1'b0;
  logic        done_ready;
  logic [4:0]  done_addr = '0;
  logic        fire_valid;
  logic        fire_ready = 1'b0;
  logic [4:0]  fire_addr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dfs_sched u_dfs_sched (
    .clk(clk), .rst_n(rst_n),
    .load_valid(load_valid), .load_addr(load_addr), .load_cnt(load_cnt),
    .load_nsucc(load_nsucc), .load_succ(load_succ), .load_vn(load_vn), .load_en(load_en),
    .done_valid(done_valid), .done_ready(done_ready), .done_addr(done_addr),
    .fire_valid(fire_valid), .fire_ready(fire_ready), .fire_addr(fire_addr)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; load_valid = 1'b0; done_valid = 1'b0; fire_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_slot(int a, int c, int n, logic [19:0] s, bit vn, bit en);
    load_valid = 1'b1; load_addr = 5'(a); load_cnt = 2'(c); load_nsucc = 3'(n);
    load_succ = s; load_vn = vn; load_en = en;
    @(posedge clk); @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic send_done(int a);
    for (int i = 0; i < 20 && !done_ready; i++) @(negedge clk);
    done_valid = 1'b1; done_addr = 5'(a);
    @(posedge clk); @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic take_fire(int exp, string tag);
    chk({tag, " fire_valid"}, fire_valid, 1);
    chk({tag, " fire_addr"}, fire_addr, exp);
    fire_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    fire_ready = 1'b0;
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R1 fire_valid", fire_valid, 0);
    chk("R1 done_ready", done_ready, 1);
  endtask

  task automatic t_priority();
    reset_dut();
    load_slot(0, 1, 0, '0, 0, 1);   // presented first and held
    load_slot(9, 0, 0, '0, 0, 0);   // count zero: ready (R2)
    load_slot(3, 2, 0, '0, 0, 1);   // ready flag set (R2)
    load_slot(6, 1, 0, '0, 0, 0);   // waits
    take_fire(0, "R10 held");
    take_fire(3, "R3 lowest");
    take_fire(9, "R2 zero count");
    chk("R2 waiting slot idle", fire_valid, 0);
  endtask

  task automatic t_join2();
    reset_dut();
    load_slot(5, 2, 0, '0, 0, 0);
    load_slot(1, 1, 1, 20'd5, 0, 0);
    load_slot(2, 1, 1, 20'd5, 0, 0);
    send_done(1);
    repeat (3) @(negedge clk);
    chk("R4 count2 one signal", fire_valid, 0);
    send_done(2);
    repeat (2) @(negedge clk);
    take_fire(5, "R4 count2 join");
    send_done(1);
    repeat (3) @(negedge clk);
    chk("R5 re-armed one signal", fire_valid, 0);
    send_done(2);
    repeat (2) @(negedge clk);
    take_fire(5, "R5 re-armed join");
  endtask

  task automatic t_join3();
    reset_dut();
    load_slot(7, 3, 0, '0, 0, 0);
    load_slot(8, 1, 1, 20'd7, 0, 0);
    send_done(8); send_done(8);
    repeat (3) @(negedge clk);
    chk("R4 count3 two signals", fire_valid, 0);
    send_done(8);
    repeat (2) @(negedge clk);
    take_fire(7, "R4 count3 join");
  endtask

  task automatic t_walk();
    reset_dut();
    for (int k = 13; k <= 16; k++) load_slot(k, 2, 0, '0, 0, 0);
    load_slot(12, 1, 4, {5'd16, 5'd15, 5'd14, 5'd13}, 0, 0);
    load_slot(17, 1, 0, '0, 0, 0);
    done_valid = 1'b1; done_addr = 5'd12;
    @(posedge clk); @(negedge clk);
    done_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R6 ready low while walking", done_ready, 0);
      @(negedge clk);
    end
    chk("R6 ready back after K cycles", done_ready, 1);
    chk("R6 first pass no fire", fire_valid, 0);
    send_done(12);
    repeat (6) @(negedge clk);
    take_fire(13, "R6 succ0");
    take_fire(14, "R6 succ1");
    take_fire(15, "R6 succ2");
    take_fire(16, "R6 succ3");
    send_done(17);
    chk("R6 zero successors ready", done_ready, 1);
  endtask

  task automatic t_shortcut();
    reset_dut();
    load_slot(10, 1, 0, '0, 1, 0);
    load_slot(11, 2, 0, '0, 0, 0);
    load_slot(31, 1, 0, '0, 1, 0);
    load_slot(4, 1, 0, '0, 0, 1);   // presented and held
    load_slot(2, 1, 0, '0, 0, 1);
    send_done(10);
    chk("R8 ready low with shortcut", done_ready, 0);
    take_fire(4, "R10 held before shortcut");
    take_fire(11, "R7 shortcut wins");
    chk("R8 ready after shortcut", done_ready, 1);
    take_fire(2, "R7 ordinary after");
    chk("R7 count untouched", fire_valid, 0);
    send_done(31);
    take_fire(0, "R7 wrap");
    chk("R7 after wrap idle", fire_valid, 0);
  endtask

  task automatic t_stall();
    reset_dut();
    load_slot(6, 1, 0, '0, 0, 1);
    for (int k = 0; k < 4; k++) begin
      chk("R10 valid held", fire_valid, 1);
      chk("R10 addr held", fire_addr, 6);
      if (k == 1) load_slot(1, 1, 0, '0, 0, 1);
      else @(negedge clk);
    end
    take_fire(6, "R10 held taken");
    take_fire(1, "R10 next");
  endtask

  task automatic t_same_edge();
    reset_dut();
    load_slot(20, 1, 0, '0, 0, 1);
    load_slot(21, 1, 1, 20'd20, 0, 0);
    done_valid = 1'b1; done_addr = 5'd21;
    @(posedge clk); @(negedge clk);
    done_valid = 1'b0; fire_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    fire_ready = 1'b0;
    take_fire(20, "R9 re-enabled");
    chk("R9 then idle", fire_valid, 0);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_join2();
    t_join3();
    t_walk();
    t_shortcut();
    t_stall();
    t_same_edge();
    summary();
  end
endmodule